// File: doc/BRIEF.md
# Masked Interrupt Aggregator Bank

This block combines 64 already-conditioned interrupt sources into a single interrupt line for a parent controller. The sources are grouped into a low bank (sources 0 to 31) and a high bank (sources 32 to 63). Each source has a software-forced pending bit and an enable bit. The forced bit is ORed into the source. The enable then masks the result, and any surviving bit raises the output line.

Software reaches the block over a plain 32-bit register bus with separate write and read strobes. Enable state and forced-pending state are never written directly. Each has one address that sets bits (write ones) and a second address that clears them, so software never needs a read-modify-write sequence. The high bank repeats the low bank's layout at a fixed stride of 0x18. Bring-up software is expected to disable every source after reset by writing all ones to each enable-clear address. A system may place several copies of the block side by side, one per parent line.

Top module: `irq_agg_bank`

## Requirements
- R1: After reset every enable bit and every forced-pending bit is 0, every readable register reads 0 while `srcIn` is 0, and `irqOut` is 0.
- R2: A read of the raw register (offset 0x04 in a bank) returns, for each of that bank's 32 sources, the source input ORed with its forced-pending bit. Source n of the bank maps to data bit n.
- R3: A read of the status register (offset 0x00 in a bank) returns the raw value ANDed with that bank's enable bits.
- R4: A write to offset 0x08 sets every enable bit whose data bit is 1 and leaves bits written 0 unchanged.
- R5: A write to offset 0x0C clears every enable bit whose data bit is 1 and leaves bits written 0 unchanged.
- R6: A write to offset 0x10 sets every forced-pending bit whose data bit is 1 and leaves the others unchanged.
- R7: A write to offset 0x14 clears every forced-pending bit whose data bit is 1 and leaves the others unchanged.
- R8: The high bank (sources 32 to 63) uses the same offsets plus 0x18, so its status, raw, enable-set, enable-clear, soft-set and soft-clear registers sit at 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C. An access to one bank never changes the other.
- R9: `irqOut` equals the OR of all 64 status bits, registered, so it follows a change in status one clock edge later.
- R10: Reads of the four set/clear addresses, of unaligned addresses and of addresses at 0x30 and above return 0. Writes to the status and raw addresses, and to unmapped addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | 64 | Conditioned interrupt sources, bit n is source n |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; `busRdata` is valid while it is high |
| busAddr | input | 6 | Byte address inside the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address while `busRe` is high, 0 otherwise |
| irqOut | output | 1 | Combined interrupt to the parent controller |

## Verification
The masking path is driven with three kinds of pending state: hardware-only source patterns, software-forced bits alone, and the two overlapping on the same source. Together they separate the OR into raw from the AND with enables. Enable and soft writes use partial masks over bits that are already set, so a design that assigns the data instead of merging it shows up as lost bits. Each pattern is applied to one bank while the other holds different values, which exposes a wrong stride or cross-bank decoding. The output line is sampled both before and after the edge that follows each change, to pin down its one-cycle latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Configuration of the aggregator slice
  localparam int BANK_W      = 32;
  localparam int NUM_BANKS   = 2;
  localparam int BANK_STRIDE = 'h18;
  localparam int ADDR_W      = 6;
  localparam int NUM_SRC     = BANK_W * NUM_BANKS;
  localparam int BANK_IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // Register offsets inside one bank
  localparam int OFF_STATUS = 'h00;
  localparam int OFF_RAW    = 'h04;
  localparam int OFF_EN_SET = 'h08;
  localparam int OFF_EN_CLR = 'h0C;
  localparam int OFF_SW_SET = 'h10;
  localparam int OFF_SW_CLR = 'h14;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_RAW    = 2'd2
  } rdKind_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  enSet;
    logic [NUM_BANKS-1:0]  enClr;
    logic [NUM_BANKS-1:0]  swSet;
    logic [NUM_BANKS-1:0]  swClr;
    logic [BANK_IDX_W-1:0] rdBank;
    rdKind_e               rdKind;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strb
);
  localparam int SPAN = NUM_BANKS * BANK_STRIDE;

  int addrInt;
  int offs;

  always_comb begin
    strb    = '0;
    addrInt = int'(busAddr);
    offs    = 0;
    if (busAddr[1:0] == 2'b00 && addrInt < SPAN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (addrInt >= b * BANK_STRIDE && addrInt < (b + 1) * BANK_STRIDE) begin
          offs = addrInt - b * BANK_STRIDE;
          if (busWe) begin
            strb.enSet[b] = (offs == OFF_EN_SET);
            strb.enClr[b] = (offs == OFF_EN_CLR);
            strb.swSet[b] = (offs == OFF_SW_SET);
            strb.swClr[b] = (offs == OFF_SW_CLR);
          end
          if (busRe) begin
            strb.rdBank = BANK_IDX_W'(b);
            if (offs == OFF_STATUS)   strb.rdKind = RD_STATUS;
            else if (offs == OFF_RAW) strb.rdKind = RD_RAW;
          end
        end
      end
    end
  end

  // One write reaches at most one register of one bank
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enSet, strb.enClr, strb.swSet, strb.swClr})); // R8

  // No write strobe without a bus write
  AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> ({strb.enSet, strb.enClr, strb.swSet, strb.swClr} == '0)); // R10
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [BANK_W-1:0]  wrData,
  input  ctrlStrobe_t        strb,
  output logic [BANK_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] enReg;
  logic [NUM_BANKS-1:0][BANK_W-1:0] swReg;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rawVec;
  logic [NUM_BANKS-1:0][BANK_W-1:0] statVec;
  logic                              irqQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] enSetMask, enClrMask, swSetMask, swClrMask;

    assign enSetMask = strb.enSet[b] ? wrData : '0;
    assign enClrMask = strb.enClr[b] ? wrData : '0;
    assign swSetMask = strb.swSet[b] ? wrData : '0;
    assign swClrMask = strb.swClr[b] ? wrData : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enReg[b] <= '0;
        swReg[b] <= '0;
      end else begin
        enReg[b] <= (enReg[b] | enSetMask) & ~enClrMask;
        swReg[b] <= (swReg[b] | swSetMask) & ~swClrMask;
      end
    end

    assign rawVec[b]  = srcIn[b*BANK_W +: BANK_W] | swReg[b];
    assign statVec[b] = rawVec[b] & enReg[b];

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strb.enSet[b] |=> ((enReg[b] & $past(wrData)) == $past(wrData))); // R4

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strb.enClr[b] |=> ((enReg[b] & $past(wrData)) == '0)); // R5

    AST_SW_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strb.swSet[b] |=> ((swReg[b] & $past(wrData)) == $past(wrData))); // R6

    AST_SW_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strb.swClr[b] |=> ((swReg[b] & $past(wrData)) == '0)); // R7

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.enSet[b] || strb.enClr[b]) |=> $stable(enReg[b])); // R8

    AST_SW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.swSet[b] || strb.swClr[b]) |=> $stable(swReg[b])); // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |statVec;
  end
  assign irqOut = irqQ;

  always_comb begin
    unique case (strb.rdKind)
      RD_STATUS: rdData = statVec[strb.rdBank];
      RD_RAW:    rdData = rawVec[strb.rdBank];
      default:   rdData = '0;
    endcase
  end

  // All enables off leaves the line low after the next edge
  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |=> !irqOut); // R9
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [BANK_W-1:0]  busWdata,
  output logic [BANK_W-1:0]  busRdata,
  output logic               irqOut
);
  ctrlStrobe_t strb;

  irq_agg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  irq_agg_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrData (busWdata),
    .strb   (strb),
    .rdData (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/irq_agg_bank_bench.sv
module irq_agg_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcIn = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [31:0] mEn [2];
  logic [31:0] mSw [2];

  always #2 clk = ~clk;  // 250 MHz

  irq_agg_bank u_irq_agg_bank (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    busRe = 1'b0; busAddr = '0;
  endtask

  function automatic logic [31:0] expRaw(input int b);
    return srcIn[b*32 +: 32] | mSw[b];
  endfunction

  function automatic logic [31:0] expStat(input int b);
    return expRaw(b) & mEn[b];
  endfunction

  function automatic logic expIrq();
    return |{expStat(0), expStat(1)};
  endfunction

  task automatic checkBanks(input string req);
    logic [31:0] d;
    for (int b = 0; b < 2; b++) begin
      busRead(6'(b*'h18 + 'h04), d); chk({req, " raw"}, d, expRaw(b));
      busRead(6'(b*'h18 + 'h00), d); chk({req, " status"}, d, expStat(b));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 'h30; a += 4) begin
      busRead(6'(a), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic t_raw();
    @(negedge clk);
    srcIn = 64'hA5A5_0001_8000_3C00;
    checkBanks("R2 R3 src only");
    chk("R3 masked irq", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic t_enable();
    busWrite(6'h08, 32'h0000_3000);  mEn[0] |= 32'h0000_3000;
    chk("R9 irq before edge", {31'h0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R9 irq after edge", {31'h0, irqOut}, 32'h1);
    busWrite(6'h08, 32'h8000_0000);  mEn[0] |= 32'h8000_0000;
    checkBanks("R4 merged set");
    busWrite(6'h0C, 32'h0000_1000);  mEn[0] &= ~32'h0000_1000;
    checkBanks("R5 partial clear");
    busWrite(6'h0C, 32'hFFFF_FFFF);  mEn[0] = '0;
    chk("R9 irq holds one edge", {31'h0, irqOut}, 32'h1);
    @(negedge clk);
    chk("R9 irq drops", {31'h0, irqOut}, 32'h0);
    checkBanks("R5 clear all");
  endtask

  task automatic t_soft();
    @(negedge clk);
    srcIn = '0;
    busWrite(6'h28, 32'h8000_0001);  mSw[1] |= 32'h8000_0001;
    busWrite(6'h10, 32'h0000_0040);  mSw[0] |= 32'h0000_0040;
    checkBanks("R6 soft set");
    busWrite(6'h20, 32'h0000_0001);  mEn[1] |= 32'h0000_0001;
    @(negedge clk);
    chk("R9 soft irq", {31'h0, irqOut}, 32'h1);
    checkBanks("R8 hi enable");
    busWrite(6'h2C, 32'h0000_0001);  mSw[1] &= ~32'h0000_0001;
    @(negedge clk);
    chk("R7 irq after soft clear", {31'h0, irqOut}, 32'h0);
    checkBanks("R7 soft clear");
    // Overlap: source and soft bit on the same line
    @(negedge clk);
    srcIn[32+31] = 1'b1;
    busWrite(6'h2C, 32'h8000_0000);  mSw[1] &= ~32'h8000_0000;
    checkBanks("R2 overlap");
  endtask

  task automatic t_bank_iso();
    busWrite(6'h08, 32'hFFFF_FFFF);  mEn[0] = 32'hFFFF_FFFF;
    busWrite(6'h14, 32'hFFFF_FFFF);  mSw[0] = '0;
    checkBanks("R8 isolation");
  endtask

  task automatic t_misc();
    logic [31:0] d;
    logic [5:0] woAddr [8] = '{6'h08, 6'h0C, 6'h10, 6'h14, 6'h20, 6'h24, 6'h28, 6'h2C};
    foreach (woAddr[i]) begin
      busRead(woAddr[i], d); chk("R10 write-only reads zero", d, 32'h0);
    end
    busRead(6'h30, d); chk("R10 unmapped read", d, 32'h0);
    busRead(6'h06, d); chk("R10 unaligned read", d, 32'h0);
    busWrite(6'h00, 32'hFFFF_FFFF);
    busWrite(6'h04, 32'hFFFF_FFFF);
    busWrite(6'h1C, 32'hFFFF_FFFF);
    busWrite(6'h30, 32'hFFFF_FFFF);
    busWrite(6'h0A, 32'hFFFF_FFFF);
    checkBanks("R10 ignored writes");
  endtask

  initial begin
    mEn[0] = '0; mEn[1] = '0; mSw[0] = '0; mSw[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_raw();
    t_enable();
    t_soft();
    t_bank_iso();
    t_misc();
    @(negedge clk);
    chk("R9 final irq", {31'h0, irqOut}, {31'h0, expIrq()});
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule